// File: doc/BRIEF.md
# Double-Precision to Integer Converter

This unit takes the raw 64-bit bit pattern of an IEEE-754 binary64 value and converts it to an integer. The target can be signed or unsigned, 32 or 64 bits wide. The answer always comes back as a 64-bit word. A three-bit conversion-mode field does two jobs. Its upper two bits pick how NaN and out-of-range values are handled: architectural clamping, saturation, or modular wrap of the exact rounded value. Its low bit forces rounding toward zero; when that bit is clear, the dynamic rounding-mode input is used instead.

Every accepted input is registered once. The registered result and the exception status flags appear together one clock later, marked by a valid strobe. The flags are invalid-conversion, signalling-NaN, inexact, fraction-inexact and a summary flag that ORs them. An execution pipeline drives the unit straight from decoded operation fields. Register file access and trap delivery are left to the surrounding logic.

Top module: `dbl2int_cvt`

## Requirements
- R1: While `rstN` is low, every output is zero. One cycle after a clock edge that samples `inValid` high, `outValid` is high and `result` and the flags belong to that input. When `inValid` was low, `outValid` is low.
- R2: The rounding encoding is 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. When `cvtMode[0]` is 1, rounding is toward zero whatever `dynRound` holds.
- R3: `intType[0]` = 1 selects an unsigned target (range 0 to 2^N-1) and 0 selects a signed one (range -2^(N-1) to 2^(N-1)-1). `intType[1]` = 1 selects N = 64 and 0 selects N = 32.
- R4: With `cvtMode[2:1]` equal to 0 (and also the reserved value 3), a NaN returns the range minimum. Positive infinity, or a rounded value above the range, returns the maximum. Negative infinity, or a rounded value below the range, returns the minimum. Any other input returns the rounded value.
- R5: With `cvtMode[2:1]` = 1, the behaviour matches R4 except that a NaN returns 0.
- R6: With `cvtMode[2:1]` = 2, infinities and NaNs return 0. A finite input is rounded exactly, then reduced modulo 2^N.
- R7: `result` is the final value modulo 2^64. A 32-bit signed value is sign-extended from bit 31, and a 32-bit unsigned value has bits 63:32 cleared.
- R8: `flagSnan` is set when the exponent field (bits 62:52) is all ones, the fraction (bits 51:0) is nonzero and bit 51 is clear.
- R9: In every mode, `flagInvalid` is set for a NaN, for an infinity, and for a rounded value outside the target range.
- R10: `flagInexact` and `flagFracInexact` are both set exactly when the conversion is not invalid and the rounded value differs from the input. Neither is set together with `flagInvalid`.
- R11: `flagSummary` equals the OR of `flagInvalid`, `flagSnan` and `flagInexact`.
- R12: Zero and denormal inputs convert to 0, +1 or -1, as the rounding direction dictates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input fields are valid this cycle |
| inBits | input | 64 | binary64 operand bit pattern |
| cvtMode | input | 3 | [2:1] range semantics, [0] force toward-zero rounding |
| intType | input | 2 | [0] unsigned target, [1] 64-bit target |
| dynRound | input | 2 | Dynamic rounding mode |
| outValid | output | 1 | Result and flags valid |
| result | output | 64 | Converted integer |
| flagInvalid | output | 1 | Invalid conversion |
| flagSnan | output | 1 | Signalling NaN operand |
| flagInexact | output | 1 | Inexact result |
| flagFracInexact | output | 1 | Fraction was rounded |
| flagSummary | output | 1 | OR of the exception flags |

## Verification
A wrong guard or sticky bit, or a wrong rounding increment, shows up in the cycle after the input. It appears as a result off by one, together with a wrong inexact flag, and only for inputs that carry fraction bits under the rounding direction affected. A wrong range limit or wrong semantics decode shows only at the boundary values and at the special inputs: it gives a clamp pattern where a wrapped value was expected, or the reverse, and flips the invalid flag. For this reason the sweep pairs every boundary operand with every combination of mode, type and rounding.

// File: rtl/d2i_pkg.sv
package d2i_pkg;
  localparam int EXP_W   = 11;
  localparam int FRAC_W  = 52;
  localparam int WORD_W  = EXP_W + FRAC_W + 1;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int POINT   = BIAS + FRAC_W;          // exponent where mantissa LSB has weight 1
  localparam int INT_W   = 64;
  localparam int HALF_W  = INT_W / 2;
  localparam int SH_W    = $clog2(INT_W);
  localparam int MAG_W   = INT_W + 2;              // room for 2^64 comparisons
  localparam int LSH_MAX = MAG_W - MANT_W;         // larger left shifts are out of every range
  localparam int RSH_CAP = MANT_W + 1;             // right shifts beyond this leave only sticky bits
  localparam int EXT_W   = MANT_W + RSH_CAP + 1;

  typedef enum logic [1:0] {
    SEM_ARCH = 2'd0,
    SEM_SAT  = 2'd1,
    SEM_WRAP = 2'd2,
    SEM_RSVD = 2'd3
  } sem_e;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_ZERO = 2'd1,
    RND_UP   = 2'd2,
    RND_DOWN = 2'd3
  } rnd_e;

  typedef struct packed {
    logic load;
    rnd_e rnd;
    logic isSigned;
    logic isWide;
    sem_e sem;
  } strobe_t;
endpackage

// File: rtl/d2i_ctrl.sv
module d2i_ctrl
  import d2i_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [2:0] cvtMode,
  input  logic [1:0] intType,
  input  logic [1:0] dynRound,
  output strobe_t    strobes,
  output logic       outValid
);
  always_comb begin
    strobes.load     = inValid;
    strobes.rnd      = cvtMode[0] ? RND_ZERO : rnd_e'(dynRound);
    strobes.isSigned = ~intType[0];
    strobes.isWide   = intType[1];
    strobes.sem      = sem_e'(cvtMode[2:1]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/d2i_path.sv
module d2i_path
  import d2i_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [WORD_W-1:0] inBits,
  output logic [INT_W-1:0]  result,
  output logic              flagInvalid,
  output logic              flagSnan,
  output logic              flagInexact,
  output logic              flagFracInexact,
  output logic              flagSummary
);
  localparam logic [EXP_W:0] POINT_V = (EXP_W + 1)'(POINT);
  localparam logic [EXP_W:0] RCAP_V  = (EXP_W + 1)'(RSH_CAP);
  localparam logic [EXP_W:0] LMAX_V  = (EXP_W + 1)'(LSH_MAX);
  localparam logic [EXP_W:0] IW_V    = (EXP_W + 1)'(INT_W);

  // operand fields
  logic              sgn;
  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic              isNan, isInf, isSnan;
  logic [MANT_W-1:0] mant;
  logic [EXP_W:0]    expEff;

  assign sgn       = inBits[WORD_W-1];
  assign expField  = inBits[WORD_W-2 -: EXP_W];
  assign fracField = inBits[FRAC_W-1:0];
  assign isNan     = (&expField) & (|fracField);
  assign isInf     = (&expField) & ~(|fracField);
  assign isSnan    = isNan & ~fracField[FRAC_W-1];
  assign mant      = {|expField, fracField};
  assign expEff    = (expField == '0) ? (EXP_W + 1)'(1) : {1'b0, expField};

  // alignment
  logic              leftPath;
  logic [EXP_W:0]    lshAmt, rshAmt, rshSat;
  logic [MAG_W-1:0]  magL;
  logic [INT_W-1:0]  lowL;
  logic              hugeL;

  assign leftPath = expEff >= POINT_V;
  assign lshAmt   = expEff - POINT_V;
  assign rshAmt   = POINT_V - expEff;
  assign rshSat   = (rshAmt > RCAP_V) ? RCAP_V : rshAmt;
  assign hugeL    = lshAmt > LMAX_V;
  assign magL     = hugeL ? '0 : (MAG_W'(mant) << lshAmt);
  assign lowL     = (lshAmt < IW_V) ? (INT_W'(mant) << lshAmt[SH_W-1:0]) : '0;

  logic [EXT_W-1:0]  ext;
  logic [MANT_W-1:0] intPart;
  logic              guardBit, stickyBit, roundUp;
  logic [MAG_W-1:0]  magR;

  assign ext       = {mant, {(RSH_CAP + 1){1'b0}}} >> rshSat;
  assign intPart   = ext[EXT_W-1 -: MANT_W];
  assign guardBit  = ext[RSH_CAP];
  assign stickyBit = |ext[RSH_CAP-1:0];

  always_comb begin
    unique case (stb.rnd)
      RND_NEAR: roundUp = guardBit & (stickyBit | intPart[0]);
      RND_ZERO: roundUp = 1'b0;
      RND_UP:   roundUp = ~sgn & (guardBit | stickyBit);
      RND_DOWN: roundUp = sgn & (guardBit | stickyBit);
      default:  roundUp = 1'b0;
    endcase
  end

  assign magR = MAG_W'(intPart) + MAG_W'(roundUp);

  logic             huge, hasFrac;
  logic [MAG_W-1:0] mag;
  logic [INT_W-1:0] low, signedLow;

  assign huge      = leftPath & hugeL;
  assign hasFrac   = ~leftPath & (guardBit | stickyBit);
  assign mag       = leftPath ? magL : magR;
  assign low       = leftPath ? lowL : magR[INT_W-1:0];
  assign signedLow = sgn ? (INT_W'(0) - low) : low;

  // range limits for the two widths
  logic [MAG_W-1:0] uMaxArr [2];
  logic [MAG_W-1:0] sMaxArr [2];
  logic [MAG_W-1:0] negArr  [2];

  for (genvar g = 0; g < 2; g++) begin : g_lim
    localparam int W = (g == 0) ? HALF_W : INT_W;
    assign uMaxArr[g] = (MAG_W'(1) << W) - MAG_W'(1);
    assign sMaxArr[g] = (MAG_W'(1) << (W - 1)) - MAG_W'(1);
    assign negArr[g]  = MAG_W'(1) << (W - 1);
  end

  logic [MAG_W-1:0] maxMag, negLim;
  logic [INT_W-1:0] maxPat, minPat, wrapVal;
  logic             outRange, invalid, inexact;

  assign maxMag = stb.isSigned ? sMaxArr[stb.isWide] : uMaxArr[stb.isWide];
  assign negLim = negArr[stb.isWide];
  assign maxPat = maxMag[INT_W-1:0];
  assign minPat = stb.isSigned ? (INT_W'(0) - negLim[INT_W-1:0]) : '0;

  always_comb begin
    if (huge)                outRange = 1'b1;
    else if (sgn && |mag)    outRange = stb.isSigned ? (mag > negLim) : 1'b1;
    else                     outRange = mag > maxMag;
  end

  assign invalid = isNan | isInf | outRange;
  assign inexact = hasFrac & ~invalid;

  always_comb begin
    if (stb.isWide)        wrapVal = signedLow;
    else if (stb.isSigned) wrapVal = {{HALF_W{signedLow[HALF_W-1]}}, signedLow[HALF_W-1:0]};
    else                   wrapVal = {{HALF_W{1'b0}}, signedLow[HALF_W-1:0]};
  end

  logic [INT_W-1:0] nextResult;

  always_comb begin
    if (stb.sem == SEM_WRAP)
      nextResult = (isNan | isInf) ? '0 : wrapVal;
    else if (isNan)
      nextResult = (stb.sem == SEM_SAT) ? '0 : minPat;
    else if (isInf | outRange)
      nextResult = sgn ? minPat : maxPat;
    else
      nextResult = signedLow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result          <= '0;
      flagInvalid     <= 1'b0;
      flagSnan        <= 1'b0;
      flagInexact     <= 1'b0;
      flagFracInexact <= 1'b0;
      flagSummary     <= 1'b0;
    end else if (stb.load) begin
      result          <= nextResult;
      flagInvalid     <= invalid;
      flagSnan        <= isSnan;
      flagInexact     <= inexact;
      flagFracInexact <= inexact;
      flagSummary     <= invalid | isSnan | inexact;
    end
  end
endmodule

// File: rtl/dbl2int_cvt.sv
module dbl2int_cvt
  import d2i_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inBits,
  input  logic [2:0]        cvtMode,
  input  logic [1:0]        intType,
  input  logic [1:0]        dynRound,
  output logic              outValid,
  output logic [INT_W-1:0]  result,
  output logic              flagInvalid,
  output logic              flagSnan,
  output logic              flagInexact,
  output logic              flagFracInexact,
  output logic              flagSummary
);
  strobe_t strobes;

  d2i_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .cvtMode  (cvtMode),
    .intType  (intType),
    .dynRound (dynRound),
    .strobes  (strobes),
    .outValid (outValid)
  );

  d2i_path u_path (
    .clk             (clk),
    .rstN            (rstN),
    .stb             (strobes),
    .inBits          (inBits),
    .result          (result),
    .flagInvalid     (flagInvalid),
    .flagSnan        (flagSnan),
    .flagInexact     (flagInexact),
    .flagFracInexact (flagFracInexact),
    .flagSummary     (flagSummary)
  );
endmodule

// File: rtl/d2i_checker.sv
module d2i_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [63:0] inBits,
  input logic [2:0]  cvtMode,
  input logic [1:0]  intType,
  input logic        outValid,
  input logic [63:0] result,
  input logic        flagInvalid,
  input logic        flagSnan,
  input logic        flagInexact,
  input logic        flagFracInexact,
  input logic        flagSummary
);
  logic expOnes, fracNz;
  assign expOnes = &inBits[62:52];
  assign fracNz  = |inBits[51:0];

  p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_trunc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && cvtMode[0] && cvtMode[2:1] != 2'd2 && intType == 2'b00 &&
     inBits == 64'h3FF8_0000_0000_0000) |=> result == 64'd1);
  p_posinf_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && cvtMode[2:1] == 2'd0 && intType == 2'b11 &&
     inBits == 64'h7FF0_0000_0000_0000) |=> result == '1);
  p_sat_nan_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && cvtMode[2:1] == 2'd1 && expOnes && fracNz) |=> result == '0);
  p_wrap_special_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && cvtMode[2:1] == 2'd2 && expOnes) |=> result == '0);
  p_sext_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && intType == 2'b00) |=> result[63:32] == {32{result[31]}});
  p_zext_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && intType == 2'b01) |=> result[63:32] == 32'd0);
  p_snan_inv_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && flagSnan) |-> flagInvalid);
  p_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !(flagInvalid && flagInexact));
  p_pair_r10: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> flagInexact == flagFracInexact);
  p_summary_r11: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> flagSummary == (flagInvalid | flagSnan | flagInexact));
endmodule

bind dbl2int_cvt d2i_checker u_chk (.*);

// File: tb/dbl2int_cvt_bench.sv
module dbl2int_cvt_bench;
  localparam int  NV    = 40;
  localparam real TWO31 = 2147483648.0;
  localparam real TWO32 = 4294967296.0;
  localparam real TWO63 = 9223372036854775808.0;
  localparam real TWO64 = 18446744073709551616.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] inBits = '0;
  logic [2:0]  cvtMode = '0;
  logic [1:0]  intType = '0;
  logic [1:0]  dynRound = '0;
  logic        outValid;
  logic [63:0] result;
  logic        flagInvalid, flagSnan, flagInexact, flagFracInexact, flagSummary;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbl2int_cvt u_dbl2int_cvt (.*);

  function automatic logic [63:0] vecBits(input int i);
    case (i)
      0:  return 64'h0;
      1:  return 64'h8000_0000_0000_0000;
      2:  return $realtobits(0.5);
      3:  return $realtobits(-0.5);
      4:  return $realtobits(1.5);
      5:  return $realtobits(-1.5);
      6:  return $realtobits(2.5);
      7:  return $realtobits(-2.5);
      8:  return $realtobits(0.3);
      9:  return $realtobits(-3.7);
      10: return 64'h0000_0000_0000_0001;
      11: return 64'h8000_0000_0000_0001;
      12: return 64'h7FF0_0000_0000_0000;
      13: return 64'hFFF0_0000_0000_0000;
      14: return 64'h7FF8_0000_0000_0000;
      15: return 64'h7FF0_0000_0000_0001;
      16: return 64'hFFF8_0000_0000_0001;
      17: return $realtobits(2147483647.0);
      18: return $realtobits(2147483647.5);
      19: return $realtobits(2147483648.0);
      20: return $realtobits(-2147483648.0);
      21: return $realtobits(-2147483648.5);
      22: return $realtobits(-2147483649.0);
      23: return $realtobits(4294967295.0);
      24: return $realtobits(4294967295.5);
      25: return $realtobits(4294967296.0);
      26: return $realtobits(9223372036854775808.0);
      27: return $realtobits(-9223372036854775808.0);
      28: return $realtobits(18446744073709551616.0);
      29: return $realtobits(18446744073709549568.0);
      30: return $realtobits(1.0e20);
      31: return $realtobits(-1.0e20);
      32: return $realtobits(4503599627370495.5);
      33: return $realtobits(4503599627370497.0);
      34: return $realtobits(1.0e300);
      35: return $realtobits(-1.0e300);
      36: return $realtobits(6442450943.75);
      37: return $realtobits(-4294967297.0);
      38: return $realtobits(123456789.49);
      default: return $realtobits(-0.75);
    endcase
  endfunction

  // non-negative integral real below 2^64 to its bit pattern
  function automatic logic [63:0] toU64(input real m);
    if (m >= TWO63) return 64'(longint'(m - TWO63)) + 64'h8000_0000_0000_0000;
    return 64'(longint'(m));
  endfunction

  function automatic real roundReal(input real r, input int rm);
    real f, d;
    case (rm)
      0: begin
        f = $floor(r);
        d = r - f;
        if (d > 0.5) return f + 1.0;
        if (d == 0.5 && ($floor(f / 2.0) * 2.0 != f)) return f + 1.0;
        return f;
      end
      1: return (r < 0.0) ? $ceil(r) : $floor(r);
      2: return $ceil(r);
      default: return $floor(r);
    endcase
  endfunction

  // reference model from the requirements
  task automatic refModel(input logic [63:0] b, input logic [2:0] cm, input logic [1:0] it,
                          input logic [1:0] dr, output logic [63:0] res,
                          output logic inv, output logic sn, output logic inx);
    real r, rr, hi, lo, m;
    logic nan, inf, neg, isU, wide, over, under;
    logic [63:0] maxB, minB, bits;
    int rm;
    nan  = (&b[62:52]) && (|b[51:0]);
    inf  = (&b[62:52]) && !(|b[51:0]);
    neg  = b[63];
    sn   = nan && !b[51];
    isU  = it[0];
    wide = it[1];
    rm   = cm[0] ? 1 : int'(dr);
    if (wide) begin
      hi   = isU ? TWO64 : TWO63;
      lo   = isU ? 0.0 : -TWO63;
      maxB = isU ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h7FFF_FFFF_FFFF_FFFF;
      minB = isU ? 64'h0 : 64'h8000_0000_0000_0000;
    end else begin
      hi   = isU ? TWO32 : TWO31;
      lo   = isU ? 0.0 : -TWO31;
      maxB = isU ? 64'h0000_0000_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
      minB = isU ? 64'h0 : 64'hFFFF_FFFF_8000_0000;
    end
    rr = 0.0; over = 1'b0; under = 1'b0;
    if (!nan && !inf) begin
      r     = $bitstoreal(b);
      rr    = roundReal(r, rm);
      over  = rr >= hi;
      under = rr < lo;
      inx   = (rr != r);
    end else begin
      inx = 1'b0;
    end
    inv = nan || inf || over || under;
    if (inv) inx = 1'b0;
    m = (rr < 0.0) ? -rr : rr;
    m = m - TWO64 * $floor(m / TWO64);
    bits = toU64(m);
    if (rr < 0.0) bits = 64'h0 - bits;
    if (cm[2:1] == 2'd2) begin
      if (nan || inf) res = '0;
      else if (wide) res = bits;
      else if (!isU) res = {{32{bits[31]}}, bits[31:0]};
      else res = {32'h0, bits[31:0]};
    end else if (nan) begin
      res = (cm[2:1] == 2'd1) ? 64'h0 : minB;
    end else if (inf || over || under) begin
      res = neg ? minB : maxB;
    end else begin
      res = bits;
    end
  endtask

  task automatic check1(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h (in=%h mode=%0d type=%0d rnd=%0d)",
               tag, got, exp, inBits, cvtMode, intType, dynRound);
    end
  endtask

  initial begin
    logic [63:0] eRes;
    logic eInv, eSn, eInx;
    string tag;
    repeat (3) @(negedge clk);
    // R1: reset state
    check1("R1 outValid in reset", 64'(outValid), 64'h0);
    check1("R1 result in reset", result, 64'h0);
    check1("R1 flags in reset",
           64'({flagInvalid, flagSnan, flagInexact, flagFracInexact, flagSummary}), 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      for (int cm = 0; cm < 8; cm++) begin
        for (int it = 0; it < 4; it++) begin
          for (int dr = 0; dr < 4; dr++) begin
            inValid  = 1'b1;
            inBits   = vecBits(v);
            cvtMode  = 3'(cm);
            intType  = 2'(it);
            dynRound = 2'(dr);
            refModel(inBits, cvtMode, intType, dynRound, eRes, eInv, eSn, eInx);
            @(negedge clk);
            // R2 R3 rounding and range selection feed every result check
            if (cvtMode[2:1] == 2'd2)      tag = "R6 R2 R3";
            else if (cvtMode[2:1] == 2'd1) tag = "R5 R2 R3";
            else                           tag = "R4 R2 R3";
            if (!intType[1])               tag = {tag, " R7"};
            if (inBits[62:52] == 11'd0)    tag = {tag, " R12"};
            check1("R1 outValid", 64'(outValid), 64'h1);
            check1({tag, " result"}, result, eRes);
            check1("R9 flagInvalid", 64'(flagInvalid), 64'(eInv));
            check1("R8 flagSnan", 64'(flagSnan), 64'(eSn));
            check1("R10 inexact pair", 64'({flagInexact, flagFracInexact}), 64'({eInx, eInx}));
            check1("R11 flagSummary", 64'(flagSummary), 64'(eInv | eSn | eInx));
          end
        end
      end
    end
    inValid = 1'b0;
    @(negedge clk);
    check1("R1 outValid idle", 64'(outValid), 64'h0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule